// File: doc/BRIEF.md
# System Reset Sequencer

This block decides when a small microcontroller core is held in reset and when it may run. Several sources can start a system reset: power-on, a brown-out request, a watchdog request, a power-on request raised by the debug logic, and a filtered low level on the shared external reset pin. The most recent source starts a fixed time-out. For the whole time-out the core reset stays high. After the time-out the block reads the two-byte reset vector and hands it to the program counter. When an internal source caused the reset, the block also pulls the shared reset pin low through an open-drain enable, so that other parts of the board are reset with it.

The block also handles the low-power stop state. A stop-entry strobe parks the core without resetting it. A wake event then starts a recovery delay. The length of that delay depends on whether the crystal oscillator is enabled. Recovery pulses reset strobes to the watchdog control register and the oscillator control register only, and leaves the reset-status bits alone. A status register records the cause of each reset, and reading it clears it.

Top module: `rst_seq_ctrl`

States: `ST_RESET` (time-out running), `ST_PIN_WAIT` (time-out over, pin still low), `ST_VEC_HI` and `ST_VEC_LO` (vector fetch), `ST_RUN`, `ST_STOP`, `ST_RECOVER` (stop recovery delay). Transitions: any source goes to `ST_RESET` from every state. `ST_RESET` goes to `ST_PIN_WAIT` on time-out with the pin low, or to `ST_VEC_HI` on time-out with the pin high. `ST_PIN_WAIT` goes to `ST_VEC_HI` once the synchronized pin reads high. `ST_VEC_HI` goes to `ST_VEC_LO`, and `ST_VEC_LO` goes to `ST_RUN`. `ST_RUN` goes to `ST_STOP` on the stop-entry strobe. `ST_STOP` goes to `ST_RECOVER` on a wake event. `ST_RECOVER` goes to `ST_VEC_HI` when its delay ends.

## Requirements
- R1: The external pin passes through a two-flop synchronizer. A low level seen for four or more consecutive clocks starts a system reset. A low level of one or two clocks has no effect on core_rst or on the status. A three-clock low level is not specified.
- R2: After the last reset source, core_rst stays high for RST_TIMEOUT cycles plus two vector-fetch cycles. A new source during the time-out restarts it. After power-on release, core_rst stays high for RST_TIMEOUT+1 cycles.
- R3: If the pin is still low when the time-out ends, core_rst stays high until the synchronized pin reads high, and then for the two fetch cycles.
- R4: rst_stat bits are: bit0 power-on (also set by the debug request), bit1 brown-out, bit2 watchdog, bit3 external pin. Sources that arrive together all set their bits. A stat_rd strobe clears the register, but a bit set in the same cycle survives the clear. After power-on the register reads 4'b0001.
- R5: pin_drive_low is high during the time-out of any reset with an internal source. It is low for a reset caused by the external pin alone, and low outside the time-out.
- R6: dbg_por_set raises dbg_por_bit. That bit starts a power-on-class reset one cycle later and clears itself during that reset. Only arst_n resets it.
- R7: stop_enter in run parks the core with core_rst low. A stop_wake while stopped holds core_rst high for 66 cycles (xtal_en low) or 5000 cycles (xtal_en high), plus the two fetch cycles. A stop_wake outside the stopped state is ignored.
- R8: Accepting a wake pulses wdt_ctl_rst and osc_ctl_rst in the wake cycle. The recovery does not drive the pin and does not change rst_stat.
- R9: Every reset exit reads address 0x0002 and then address 0x0003 in consecutive cycles. In the second cycle pc_load is high and pc_value is {byte at 0x0002, byte at 0x0003}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-on event, asynchronous active low |
| ext_rst_n | input | 1 | Shared reset pin level, active low |
| bo_req | input | 1 | Brown-out reset request |
| wdt_req | input | 1 | Watchdog reset request |
| dbg_por_set | input | 1 | Debug write that sets the power-on request bit |
| stop_enter | input | 1 | Stop-entry strobe from the core |
| stop_wake | input | 1 | Stop recovery wake event |
| xtal_en | input | 1 | Crystal oscillator enabled |
| stat_rd | input | 1 | Status register read strobe |
| vec_data | input | 8 | Program memory read data |
| core_rst | output | 1 | Core held in reset |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the reset pin |
| rst_stat | output | 4 | Reset cause bits |
| dbg_por_bit | output | 1 | Debug power-on request bit |
| wdt_ctl_rst | output | 1 | Reset strobe for the watchdog control register |
| osc_ctl_rst | output | 1 | Reset strobe for the oscillator control register (internal oscillator on and selected) |
| vec_rd | output | 1 | Program memory read request |
| vec_addr | output | ADDR_W | Program memory read address |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | 16 | Reset vector for the program counter |

## Verification
A brown-out or watchdog request raises core_rst one edge later. A debug request raises it two edges later. An external pulse raises it six edges after the pin first falls: two for the synchronizer and four for the length count. The high phase lasts the time-out plus two fetch cycles. A held pin releases core_rst five edges after it rises. A recovery lasts its delay plus two cycles. Wake strobes are combinational in the wake cycle. The bench drives each stimulus just after a falling edge. At every later falling edge it counts how many samples of core_rst are low before the rise and how many are high. It compares both counts, the first pin_drive_low sample, the fetched vector and the status word with values from formulas built on these latencies.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int STAT_W   = 4;
    localparam int STAT_POR = 0;
    localparam int STAT_BO  = 1;
    localparam int STAT_WDT = 2;
    localparam int STAT_EXT = 3;
    localparam int BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_PIN_WAIT,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_RUN,
        ST_STOP,
        ST_RECOVER
    } seq_state_e;

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_n,
    output logic pin_low,
    output logic trig
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW - 1);
    localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_LOW);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
        end
    end

    assign pin_low = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt_q <= '0;
        end else if (!pin_low) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_SAT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign trig = pin_low && (low_cnt_q == CNT_LAST);

endmodule

// File: rtl/rst_src_status.sv
module rst_src_status
    import rst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              arst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(1) << STAT_POR;

    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stat_q <= POR_VAL;
        end else begin
            stat_q <= set_i | (stat_q & ~{STAT_W{rd_i}});
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/rst_vec_fetch.sv
module rst_vec_fetch
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 2
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                fetch_hi,
    input  logic                fetch_lo,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                rd_en,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                pc_load,
    output logic [2*BYTE_W-1:0] pc_value
);
    localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(VEC_BASE + 1);

    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hi_q <= '0;
        end else if (fetch_hi) begin
            hi_q <= rd_data;
        end
    end

    assign rd_en    = fetch_hi | fetch_lo;
    assign rd_addr  = fetch_lo ? ADDR_LO : ADDR_HI;
    assign pc_load  = fetch_lo;
    assign pc_value = {hi_q, rd_data};

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int RST_TIMEOUT = 66,
    parameter int SMR_FAST    = 66,
    parameter int SMR_XTAL    = 5000,
    parameter int PIN_MIN_LOW = 4,
    parameter int ADDR_W      = 16,
    parameter int VEC_BASE    = 2
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                ext_rst_n,
    input  logic                bo_req,
    input  logic                wdt_req,
    input  logic                dbg_por_set,
    input  logic                stop_enter,
    input  logic                stop_wake,
    input  logic                xtal_en,
    input  logic                stat_rd,
    input  logic [7:0]          vec_data,
    output logic                core_rst,
    output logic                pin_drive_low,
    output logic [3:0]          rst_stat,
    output logic                dbg_por_bit,
    output logic                wdt_ctl_rst,
    output logic                osc_ctl_rst,
    output logic                vec_rd,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic                pc_load,
    output logic [15:0]         pc_value
);
    localparam int TMR_MAX_A = (RST_TIMEOUT > SMR_FAST) ? RST_TIMEOUT : SMR_FAST;
    localparam int TMR_MAX   = (TMR_MAX_A > SMR_XTAL) ? TMR_MAX_A : SMR_XTAL;
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] RST_LAST  = TW'(RST_TIMEOUT - 1);
    localparam logic [TW-1:0] FAST_LAST = TW'(SMR_FAST - 1);
    localparam logic [TW-1:0] XTAL_LAST = TW'(SMR_XTAL - 1);

    seq_state_e  state_q, state_nx;
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] smr_last_q;
    logic        int_q;
    logic        dbg_q;
    logic        pin_low;
    logic        ext_trig;
    logic        dbg_trig;
    logic        int_src;
    logic        src_evt;
    logic        wake_acc;
    logic        tmr_done;
    logic        fetch_hi;
    logic        fetch_lo;
    logic [STAT_W-1:0] stat_set;

    rst_pin_filter #(
        .SYNC_STAGES (2),
        .MIN_LOW     (PIN_MIN_LOW)
    ) pin_filt_i (
        .clk     (clk),
        .arst_n  (arst_n),
        .pin_n   (ext_rst_n),
        .pin_low (pin_low),
        .trig    (ext_trig)
    );

    // source collection
    assign dbg_trig = dbg_q && (state_q != ST_RESET);
    assign int_src  = bo_req | wdt_req | dbg_trig;
    assign src_evt  = int_src | ext_trig;
    assign wake_acc = (state_q == ST_STOP) && stop_wake && !src_evt;

    always_comb begin
        stat_set           = '0;
        stat_set[STAT_POR] = dbg_trig;
        stat_set[STAT_BO]  = bo_req;
        stat_set[STAT_WDT] = wdt_req;
        stat_set[STAT_EXT] = ext_trig;
    end

    rst_src_status stat_i (
        .clk    (clk),
        .arst_n (arst_n),
        .set_i  (stat_set),
        .rd_i   (stat_rd),
        .stat_o (rst_stat)
    );

    assign tmr_done = ((state_q == ST_RESET)   && (tmr_q == RST_LAST)) ||
                      ((state_q == ST_RECOVER) && (tmr_q == smr_last_q));

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (src_evt) begin
            state_nx = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET:    if (tmr_done) state_nx = pin_low ? ST_PIN_WAIT : ST_VEC_HI;
                ST_PIN_WAIT: if (!pin_low) state_nx = ST_VEC_HI;
                ST_VEC_HI:   state_nx = ST_VEC_LO;
                ST_VEC_LO:   state_nx = ST_RUN;
                ST_RUN:      if (stop_enter) state_nx = ST_STOP;
                ST_STOP:     if (stop_wake) state_nx = ST_RECOVER;
                ST_RECOVER:  if (tmr_done) state_nx = ST_VEC_HI;
                default:     state_nx = ST_RESET;
            endcase
        end
    end

    // state register and its companions
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q    <= ST_RESET;
            tmr_q      <= '0;
            smr_last_q <= FAST_LAST;
            int_q      <= 1'b1;
            dbg_q      <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (src_evt || (state_nx != state_q)) begin
                tmr_q <= '0;
            end else if ((state_q == ST_RESET) || (state_q == ST_RECOVER)) begin
                tmr_q <= tmr_q + 1'b1;
            end
            if (wake_acc) begin
                smr_last_q <= xtal_en ? XTAL_LAST : FAST_LAST;
            end
            if (src_evt) begin
                int_q <= int_src;
            end
            if (dbg_por_set) begin
                dbg_q <= 1'b1;
            end else if (state_q == ST_RESET) begin
                dbg_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        core_rst      = !((state_q == ST_RUN) || (state_q == ST_STOP));
        pin_drive_low = (state_q == ST_RESET) && int_q;
        wdt_ctl_rst   = wake_acc;
        osc_ctl_rst   = wake_acc;
        fetch_hi      = (state_q == ST_VEC_HI);
        fetch_lo      = (state_q == ST_VEC_LO);
        dbg_por_bit   = dbg_q;
    end

    rst_vec_fetch #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) vec_i (
        .clk      (clk),
        .arst_n   (arst_n),
        .fetch_hi (fetch_hi),
        .fetch_lo (fetch_lo),
        .rd_data  (vec_data),
        .rd_en    (vec_rd),
        .rd_addr  (vec_addr),
        .pc_load  (pc_load),
        .pc_value (pc_value)
    );

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 2
) (
    input logic              clk,
    input logic              arst_n,
    input logic              bo_req,
    input logic              wdt_req,
    input logic              stat_rd,
    input logic              core_rst,
    input logic              pin_drive_low,
    input logic [3:0]        rst_stat,
    input logic              wdt_ctl_rst,
    input logic              vec_rd,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              ext_trig,
    input logic              dbg_trig
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(VEC_BASE + 1);

    AST_INT_SRC_DRIVES_PIN: assert property (@(posedge clk) disable iff (!arst_n)
        (bo_req || wdt_req) |=> (core_rst && pin_drive_low)); // R5
    AST_EXT_ONLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!arst_n)
        (ext_trig && !bo_req && !wdt_req && !dbg_trig) |=> (core_rst && !pin_drive_low)); // R5
    AST_EXT_SETS_STATUS: assert property (@(posedge clk) disable iff (!arst_n)
        ext_trig |=> rst_stat[3]); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
        (stat_rd && !bo_req && !wdt_req && !ext_trig && !dbg_trig) |=> (rst_stat == 4'b0000)); // R4
    AST_DBG_POR_CLASS: assert property (@(posedge clk) disable iff (!arst_n)
        dbg_trig |=> (core_rst && rst_stat[0])); // R6
    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!arst_n)
        (vec_rd && (vec_addr == A_LO)) |-> ($past(vec_rd) && ($past(vec_addr) == A_HI))); // R9
    AST_WAKE_FROM_STOP: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_ctl_rst |-> !core_rst); // R7
    AST_WAKE_NO_DRIVE: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_ctl_rst |=> (core_rst && !pin_drive_low)); // R8

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
) chk_i (
    .clk           (clk),
    .arst_n        (arst_n),
    .bo_req        (bo_req),
    .wdt_req       (wdt_req),
    .stat_rd       (stat_rd),
    .core_rst      (core_rst),
    .pin_drive_low (pin_drive_low),
    .rst_stat      (rst_stat),
    .wdt_ctl_rst   (wdt_ctl_rst),
    .vec_rd        (vec_rd),
    .vec_addr      (vec_addr),
    .ext_trig      (ext_trig),
    .dbg_trig      (dbg_trig)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    localparam int T    = 66;
    localparam int FAST = 66;
    localparam int XTAL = 5000;

    logic        clk = 1'b0;
    logic        arst_n, ext_rst_n, bo_req, wdt_req, dbg_por_set;
    logic        stop_enter, stop_wake, xtal_en, stat_rd;
    logic [7:0]  vec_data;
    logic        core_rst, pin_drive_low, dbg_por_bit, wdt_ctl_rst, osc_ctl_rst;
    logic        vec_rd, pc_load;
    logic [3:0]  rst_stat;
    logic [15:0] vec_addr, pc_value;
    logic [7:0]  mem_hi, mem_lo;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int pin_left = 0;
    int late_at  = 0;

    always #4 clk = ~clk;

    assign vec_data = (vec_addr == 16'h0002) ? mem_hi :
                      (vec_addr == 16'h0003) ? mem_lo : 8'h00;

    rst_seq_ctrl dut_i (
        .clk(clk), .arst_n(arst_n), .ext_rst_n(ext_rst_n), .bo_req(bo_req),
        .wdt_req(wdt_req), .dbg_por_set(dbg_por_set), .stop_enter(stop_enter),
        .stop_wake(stop_wake), .xtal_en(xtal_en), .stat_rd(stat_rd),
        .vec_data(vec_data), .core_rst(core_rst), .pin_drive_low(pin_drive_low),
        .rst_stat(rst_stat), .dbg_por_bit(dbg_por_bit), .wdt_ctl_rst(wdt_ctl_rst),
        .osc_ctl_rst(osc_ctl_rst), .vec_rd(vec_rd), .vec_addr(vec_addr),
        .pc_load(pc_load), .pc_value(pc_value)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ext_width(input int n);
        return ((n - 1) > (T + 2)) ? (n - 1) : (T + 2);
    endfunction

    task automatic clear_strobes();
        bo_req = 1'b0; wdt_req = 1'b0; dbg_por_set = 1'b0;
        stop_enter = 1'b0; stop_wake = 1'b0; stat_rd = 1'b0;
    endtask

    // counts low samples before core_rst rises (lead) and high samples (width)
    task automatic measure(output int lead, output int width, output int pcv,
                           output int order_ok, output int drive_first);
        int  prev_addr;
        bit  seen;
        lead = 0; width = 0; pcv = -1; order_ok = 0; drive_first = -1;
        prev_addr = -1; seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (vec_rd) begin
                if (vec_addr == 16'h0003 && prev_addr == 2) order_ok = 1;
                prev_addr = int'(vec_addr);
            end else begin
                prev_addr = -1;
            end
            if (pc_load) pcv = int'(pc_value);
            clear_strobes();
            if (pin_left > 0) begin
                pin_left--;
                if (pin_left == 0) ext_rst_n = 1'b1;
            end
            if (late_at > 0 && i + 1 == late_at) bo_req = 1'b1;
            if (core_rst) begin
                if (!seen) drive_first = int'(pin_drive_low);
                seen = 1'b1;
                width++;
            end else if (seen) begin
                break;
            end else begin
                lead++;
                if (lead >= 16) break;
            end
        end
        late_at = 0;
    endtask

    task automatic read_clear(input string req);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(req, "status after read", int'(rst_stat), 0);
    endtask

    task automatic new_vector();
        mem_hi = 8'($urandom);
        mem_lo = 8'($urandom);
    endtask

    task automatic check_exit(input string req, input int pcv, input int ok);
        chk("R9", {req, " vector value"}, pcv, int'({mem_hi, mem_lo}));
        chk("R9", {req, " vector order"}, ok, 1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lead, width, pcv, ok, drv, kind, n, expst;
        void'($urandom(32'h00C0FFEE));
        arst_n = 1'b0; ext_rst_n = 1'b1; xtal_en = 1'b0;
        clear_strobes();
        new_vector();
        repeat (3) @(negedge clk);
        // reset state
        chk("R4", "status during power-on", int'(rst_stat), 1);
        chk("R5", "pin drive during power-on", int'(pin_drive_low), 1);
        chk("R2", "core reset during power-on", int'(core_rst), 1);
        chk("R6", "debug bit during power-on", int'(dbg_por_bit), 0);
        arst_n = 1'b1;
        measure(lead, width, pcv, ok, drv);
        chk("R2", "power-on width", width, T + 1);
        check_exit("power-on", pcv, ok);
        chk("R4", "status after power-on", int'(rst_stat), 1);
        read_clear("R4");

        // R2 restart by a later source
        new_vector();
        wdt_req = 1'b1; late_at = 30;
        measure(lead, width, pcv, ok, drv);
        chk("R2", "restart width", width, T + 32);
        check_exit("restart", pcv, ok);
        chk("R4", "both sources recorded", int'(rst_stat), 6);

        // R4 read in the same cycle as a new source
        new_vector();
        stat_rd = 1'b1; bo_req = 1'b1;
        measure(lead, width, pcv, ok, drv);
        chk("R4", "set survives read", int'(rst_stat), 2);
        read_clear("R4");

        // R6 debug request, directed
        new_vector();
        dbg_por_set = 1'b1;
        @(negedge clk);
        clear_strobes();
        chk("R6", "debug bit raised", int'(dbg_por_bit), 1);
        chk("R6", "no reset yet", int'(core_rst), 0);
        measure(lead, width, pcv, ok, drv);
        chk("R6", "debug lead", lead, 0);
        chk("R6", "debug width", width, T + 2);
        chk("R5", "debug drives pin", drv, 1);
        chk("R6", "debug bit self-clears", int'(dbg_por_bit), 0);
        chk("R4", "debug sets power-on bit", int'(rst_stat), 1);
        read_clear("R4");

        // R3 long hold of the pin
        new_vector();
        n = T + 20;
        ext_rst_n = 1'b0; pin_left = n;
        measure(lead, width, pcv, ok, drv);
        chk("R3", "long hold lead", lead, 5);
        chk("R3", "long hold width", width, n - 1);
        check_exit("long hold", pcv, ok);
        chk("R4", "external bit", int'(rst_stat), 8);
        read_clear("R4");

        // R7 / R8 stop recovery, both oscillator settings
        for (int x = 0; x < 2; x++) begin
            new_vector();
            xtal_en = (x == 1);
            stop_enter = 1'b1;
            @(negedge clk);
            clear_strobes();
            chk("R7", "stopped core not in reset", int'(core_rst), 0);
            stop_wake = 1'b1;
            #1;
            chk("R8", "watchdog control strobe", int'(wdt_ctl_rst), 1);
            chk("R8", "oscillator control strobe", int'(osc_ctl_rst), 1);
            measure(lead, width, pcv, ok, drv);
            chk("R7", "recovery lead", lead, 0);
            chk("R7", "recovery width", width, ((x == 1) ? XTAL : FAST) + 2);
            chk("R8", "recovery leaves pin alone", drv, 0);
            chk("R8", "recovery leaves status", int'(rst_stat), 0);
            check_exit("recovery", pcv, ok);
        end
        xtal_en = 1'b0;

        // R7 wake while running is ignored
        stop_wake = 1'b1;
        #1;
        chk("R8", "no strobe while running", int'(wdt_ctl_rst), 0);
        measure(lead, width, pcv, ok, drv);
        chk("R7", "wake in run ignored", width, 0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            repeat (1 + ($urandom % 4)) @(negedge clk);
            new_vector();
            kind = int'($urandom % 6);
            n = 0;
            unique case (kind)
                0: begin wdt_req = 1'b1; expst = 4; end
                1: begin bo_req = 1'b1; expst = 2; end
                2: begin wdt_req = 1'b1; bo_req = 1'b1; expst = 6; end
                3: begin dbg_por_set = 1'b1; expst = 1; end
                4: begin n = 1 + int'($urandom % 2); ext_rst_n = 1'b0; pin_left = n; expst = 0; end
                default: begin n = 4 + int'($urandom % (T + 7)); ext_rst_n = 1'b0; pin_left = n; expst = 8; end
            endcase
            measure(lead, width, pcv, ok, drv);
            if (kind == 4) begin
                chk("R1", "short pulse ignored", width, 0);
            end else if (kind == 5) begin
                chk("R1", "filtered pulse lead", lead, 5);
                chk("R3", "pulse width", width, ext_width(n));
                chk("R5", "external pin not driven", drv, 0);
                check_exit("external", pcv, ok);
            end else begin
                chk("R2", "internal lead", lead, (kind == 3) ? 1 : 0);
                chk("R2", "internal width", width, T + 2);
                chk("R5", "internal drives pin", drv, 1);
                check_exit("internal", pcv, ok);
            end
            if (pin_left > 0) begin
                repeat (pin_left) @(negedge clk);
                ext_rst_n = 1'b1; pin_left = 0;
                repeat (4) @(negedge clk);
            end
            chk("R4", "status word", int'(rst_stat), expst);
            read_clear("R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule